// File: doc/BRIEF.md
# Thermal Event Comparator with Hysteresis

This block watches a stream of signed temperature samples and raises a thermal event when a sample leaves a programmed window or exceeds a critical limit. There are three limits: an upper alarm, a lower alarm and a critical trip. Each limit drives its own condition flag. A flag sets as soon as a sample crosses its limit. It releases only after the temperature has come back past the limit by a selectable hysteresis margin.

The event can be presented in two ways. In comparator mode it follows the live condition flags. In interrupt mode any change of the triggering condition latches the event, and it stays latched until software sends a clear pulse. A clear has no effect while the critical flag is set. A critical-only option restricts triggering to the critical flag. The output pad is modelled as a drive-enable and a level. An enable bit and a polarity bit select between active-low open-drain use and active-high use. A polarity-independent status bit reports whether the event is currently asserted.

Samples are taken only when the sample strobe is high. While the block is shut down, incoming samples are ignored and every condition flag keeps its value.

Top module: `thermal_event_cmp`

## Requirements
- R1: Condition flags change only on a clock edge where `sample_valid` is 1 and `shutdown` is 0. The result is visible at the outputs in the cycle after that edge.
- R2: The upper flag sets when temp > `lim_high`. The critical flag sets when temp > `lim_crit`. The lower flag sets when temp < `lim_low`. All comparisons are signed, in 1/16 °C units.
- R3: A set upper or critical flag releases only once temp <= limit − H. A set lower flag releases only once temp >= `lim_low` + H. H is 0, 24, 48 or 96 for `hyst_sel` values 0, 1, 2 and 3.
- R4: In comparator mode (`int_mode`=0) the event equals critical flag OR (NOT `crit_only` AND (upper OR lower)), and `clr_pulse` has no effect.
- R5: In interrupt mode (`int_mode`=1) a sample that changes the triggering condition, in either direction, latches the event. The event stays asserted until a `clr_pulse`.
- R6: In interrupt mode, while the critical flag is set, `clr_pulse` is ignored and the event remains asserted.
- R7: With `crit_only`=1 the upper and lower flags never assert the event.
- R8: With `evt_en`=0, `evt_status` is 0. For `evt_pol`=0 the pad is undriven (`evt_drive_en`=0). For `evt_pol`=1 it is driven low (`evt_drive_en`=1, `evt_level`=0).
- R9: With `evt_en`=1 and `evt_pol`=0, the pad is driven low exactly when the event is asserted. With `evt_pol`=1 it is always driven, with `evt_level` equal to the event.
- R10: While `shutdown`=1, samples are ignored and the flags hold their last values.
- R11: After reset all flags and the latch are clear, so `evt_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | Strobe: `temp_in` holds a new sample |
| temp_in | input | 13 | Signed temperature, 1/16 °C |
| lim_high | input | 13 | Signed upper alarm limit |
| lim_low | input | 13 | Signed lower alarm limit |
| lim_crit | input | 13 | Signed critical limit |
| hyst_sel | input | 2 | Hysteresis select (0, 1.5, 3, 6 °C) |
| shutdown | input | 1 | Freeze the flags and ignore samples |
| crit_only | input | 1 | Trigger on the critical limit only |
| int_mode | input | 1 | 0 comparator, 1 latched interrupt |
| evt_en | input | 1 | Event output enable |
| evt_pol | input | 1 | 0 active low, 1 active high |
| clr_pulse | input | 1 | Clear the latched event |
| evt_drive_en | output | 1 | Pad drive enable |
| evt_level | output | 1 | Pad level when driven |
| evt_status | output | 1 | Event asserted, polarity independent |

## Verification
Some rules are checked on every cycle by properties:
- the pad mapping when the output is disabled or active low;
- status forced low when the output is disabled;
- a critical flag holding the interrupt event;
- a critical flag rising only after a qualifying sample above the limit;
- flags frozen during shutdown.

Other behaviours depend on sample history, and only the bench's scenarios show them:
- the exact hysteresis release points for each margin;
- the lower-limit window;
- re-latching on a downward crossing;
- clear pulses being ignored in comparator mode.

// File: rtl/thermal_event_cmp.sv
module thermal_event_cmp #(
  parameter int TW = 13,
  parameter int FB = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_valid,
  input  logic signed [TW-1:0] temp_in,
  input  logic signed [TW-1:0] lim_high,
  input  logic signed [TW-1:0] lim_low,
  input  logic signed [TW-1:0] lim_crit,
  input  logic [1:0]           hyst_sel,
  input  logic                 shutdown,
  input  logic                 crit_only,
  input  logic                 int_mode,
  input  logic                 evt_en,
  input  logic                 evt_pol,
  input  logic                 clr_pulse,
  output logic                 evt_drive_en,
  output logic                 evt_level,
  output logic                 evt_status
);
  localparam int XW = TW + 2;

  logic signed [XW-1:0] t_x, hi_x, lo_x, cr_x, marg;
  logic hi_q, lo_q, cr_q, latch_q;
  logic hi_nx, lo_nx, cr_nx, trig_q, trig_nx, take, active;

  assign t_x  = {{2{temp_in[TW-1]}},  temp_in};
  assign hi_x = {{2{lim_high[TW-1]}}, lim_high};
  assign lo_x = {{2{lim_low[TW-1]}},  lim_low};
  assign cr_x = {{2{lim_crit[TW-1]}}, lim_crit};

  always_comb begin
    if (hyst_sel == 2'd0) marg = '0;
    else                  marg = XW'(3 << (FB - 2 + int'(hyst_sel)));
  end

  assign hi_nx = hi_q ? (t_x > hi_x - marg) : (t_x > hi_x);
  assign cr_nx = cr_q ? (t_x > cr_x - marg) : (t_x > cr_x);
  assign lo_nx = lo_q ? (t_x < lo_x + marg) : (t_x < lo_x);

  assign take    = sample_valid & ~shutdown;
  assign trig_q  = cr_q  | (~crit_only & (hi_q  | lo_q));
  assign trig_nx = cr_nx | (~crit_only & (hi_nx | lo_nx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
      cr_q <= 1'b0;
    end else if (take) begin
      hi_q <= hi_nx;
      lo_q <= lo_nx;
      cr_q <= cr_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              latch_q <= 1'b0;
    else if (take && (trig_nx != trig_q))    latch_q <= 1'b1;
    else if (clr_pulse && int_mode && !cr_q) latch_q <= 1'b0;
  end

  assign active       = int_mode ? (latch_q | cr_q) : trig_q;
  assign evt_status   = evt_en & active;
  assign evt_drive_en = evt_pol | evt_status;
  assign evt_level    = evt_pol & evt_status;
endmodule

module thermal_event_cmp_chk #(
  parameter int TW = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sample_valid,
  input logic                 shutdown,
  input logic signed [TW-1:0] temp_in,
  input logic signed [TW-1:0] lim_crit,
  input logic                 evt_en,
  input logic                 evt_pol,
  input logic                 int_mode,
  input logic                 evt_status,
  input logic                 evt_drive_en,
  input logic                 evt_level,
  input logic                 cr_q
);
  a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_en |-> !evt_status);

  a_r8_off_pad: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_en |-> (evt_drive_en == evt_pol) && !evt_level);

  a_r9_low_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_en && !evt_pol) |-> (evt_drive_en == evt_status) && !evt_level);

  a_r6_crit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_en && int_mode && cr_q) |-> evt_status);

  a_r2_crit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cr_q) |-> $past(sample_valid && !shutdown && (temp_in > lim_crit)));

  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shutdown) |-> $stable(cr_q));
endmodule

bind thermal_event_cmp thermal_event_cmp_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .shutdown(shutdown),
  .temp_in(temp_in), .lim_crit(lim_crit), .evt_en(evt_en), .evt_pol(evt_pol),
  .int_mode(int_mode), .evt_status(evt_status), .evt_drive_en(evt_drive_en),
  .evt_level(evt_level), .cr_q(cr_q)
);

// File: tb/thermal_event_cmp_test.sv
`timescale 1ns/1ps
module thermal_event_cmp_test;
  logic clk = 1'b0, rst_n = 1'b0, sample_valid = 1'b0;
  logic signed [12:0] temp_in = '0;
  logic signed [12:0] lim_high = 13'sd400, lim_low = 13'sd0, lim_crit = 13'sd800;
  logic [1:0] hyst_sel = 2'd0;
  logic shutdown = 1'b0, crit_only = 1'b0, int_mode = 1'b0;
  logic evt_en = 1'b1, evt_pol = 1'b0, clr_pulse = 1'b0;
  logic evt_drive_en, evt_level, evt_status;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  thermal_event_cmp uut (.*);

  // {hyst[1:0], crit_only, temp[12:0], expected status}
  localparam logic [16:0] VEC [0:12] = '{
    {2'd0, 1'b0,  13'sd100, 1'b0},
    {2'd0, 1'b0,  13'sd401, 1'b1},
    {2'd0, 1'b0,  13'sd400, 1'b0},
    {2'd1, 1'b0,  13'sd401, 1'b1},
    {2'd1, 1'b0,  13'sd390, 1'b1},
    {2'd1, 1'b0,  13'sd376, 1'b0},
    {2'd3, 1'b0,  -13'sd1,  1'b1},
    {2'd3, 1'b0,  13'sd95,  1'b1},
    {2'd3, 1'b0,  13'sd96,  1'b0},
    {2'd3, 1'b1,  13'sd500, 1'b0},
    {2'd3, 1'b1,  13'sd801, 1'b1},
    {2'd2, 1'b1,  13'sd760, 1'b1},
    {2'd2, 1'b1,  13'sd752, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sample(input logic signed [12:0] t);
    @(negedge clk);
    temp_in = t;
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk);
    clr_pulse = 1'b1;
    @(negedge clk);
    clr_pulse = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R11 status", {7'd0, evt_status}, 8'd0);
    check("R11 drive", {7'd0, evt_drive_en}, 8'd0);
    rst_n = 1'b1;

    // R2 R3 R7 table walk in comparator mode
    for (int i = 0; i < 13; i++) begin
      hyst_sel = VEC[i][16:15];
      crit_only = VEC[i][14];
      sample(VEC[i][13:1]);
      check($sformatf("R2/R3/R7 vec %0d", i), {7'd0, evt_status}, {7'd0, VEC[i][0]});
    end

    // R1: temp change without strobe
    do_reset();
    hyst_sel = 2'd0;
    crit_only = 1'b0;
    @(negedge clk);
    temp_in = 13'sd401;
    repeat (3) @(negedge clk);
    check("R1 no strobe", {7'd0, evt_status}, 8'd0);

    // R4: comparator ignores clear
    sample(13'sd401);
    check("R4 event", {7'd0, evt_status}, 8'd1);
    clear();
    check("R4 clear ignored", {7'd0, evt_status}, 8'd1);

    // R9 pad mapping
    check("R9 active low drive", {6'd0, evt_drive_en, evt_level}, 8'b10);
    evt_pol = 1'b1;
    @(negedge clk);
    check("R9 active high drive", {6'd0, evt_drive_en, evt_level}, 8'b11);

    // R8 disabled
    evt_en = 1'b0;
    @(negedge clk);
    check("R8 status off", {7'd0, evt_status}, 8'd0);
    check("R8 pol1 pad", {6'd0, evt_drive_en, evt_level}, 8'b10);
    evt_pol = 1'b0;
    @(negedge clk);
    check("R8 pol0 pad", {6'd0, evt_drive_en, evt_level}, 8'b00);
    evt_en = 1'b1;

    // R10 shutdown
    shutdown = 1'b1;
    sample(13'sd100);
    check("R10 frozen", {7'd0, evt_status}, 8'd1);
    shutdown = 1'b0;
    sample(13'sd100);
    check("R10 resumed", {7'd0, evt_status}, 8'd0);
    evt_pol = 1'b1;
    @(negedge clk);
    check("R9 pol1 idle pad", {6'd0, evt_drive_en, evt_level}, 8'b10);
    evt_pol = 1'b0;

    // R5 R6 interrupt mode
    do_reset();
    int_mode = 1'b1;
    sample(13'sd401);
    check("R5 latch up", {7'd0, evt_status}, 8'd1);
    sample(13'sd100);
    check("R5 latch on release", {7'd0, evt_status}, 8'd1);
    clear();
    check("R5 cleared", {7'd0, evt_status}, 8'd0);
    sample(13'sd100);
    check("R5 no crossing", {7'd0, evt_status}, 8'd0);
    sample(13'sd900);
    check("R6 crit latch", {7'd0, evt_status}, 8'd1);
    clear();
    check("R6 clear ignored", {7'd0, evt_status}, 8'd1);
    sample(13'sd100);
    check("R5 relatch down", {7'd0, evt_status}, 8'd1);
    clear();
    check("R6 clear after crit", {7'd0, evt_status}, 8'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule